// File: doc/BRIEF.md
# Mode-Switched Programmable Feedback Divider

This block sits in the feedback path of a frequency synthesizer loop. It receives two synchronous tick streams, one from a high-band front end and one from a low-band front end. It counts the ticks of whichever stream is selected and emits a one-cycle pulse toward the phase comparator each time a full divide period has elapsed. Each tick is a one-cycle-wide enable in the block's clock domain.

Two mode bits choose how the block works. The band bit picks the tick stream. The step bit picks where the least significant bit of the 16-bit divisor word sits. In high-band mode, a fixed divide-by-2 stage runs ahead of the counter, so the overall ratio is twice the programmed setting. In low-band coarse mode, the low four bits of the word are dropped and bits 15..4 form the setting.

A new setting or mode is picked up only when a divide period ends, so an output period is never cut short. An inhibit input stops all division and raises the pull-down and high-impedance indicators.

Top module: `fbdiv_top`

## Requirements
- R1: While reset is low at a clock edge, `fb_pulse` is 0 and `hi_band_act` is 0 after that edge.
- R2: With `band_hi`=1 latched, `fb_pulse` fires once every 2·N `hf_tick` events, where N is the setting. `lf_tick` has no effect, and `hi_band_act` reads 1.
- R3: With `band_hi`=0 and `step_fine`=1 latched, `fb_pulse` fires once every N `lf_tick` events, where N = `div_word`. `hf_tick` has no effect.
- R4: With `band_hi`=0 and `step_fine`=0 latched, N = `div_word[15:4]`, and `div_word[3:0]` has no effect.
- R5: A setting below the floor for its mode is raised to the floor. The floor is 272 for the two full-word modes and 4 for coarse mode.
- R6: `fb_pulse` is high for exactly one cycle. It rises in the cycle after the clock edge at which the terminal counted event is sampled.
- R7: The divisor word and mode bits are sampled only at the terminal event, and they set the length of the following period and the active tick stream. Changes made between terminal events have no effect on the period in progress.
- R8: While `inhibit`=1, no pulse is emitted, the count and the divide-by-2 phase are cleared, and `hi_band_act` follows `band_hi`. After release, and likewise after reset, the first counted event is a terminal event: it emits a pulse and loads the setting.
- R9: `in_pulldown` and `cp_hiz` equal `inhibit` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hf_tick | input | 1 | High-band input event, one cycle wide |
| lf_tick | input | 1 | Low-band input event, one cycle wide |
| div_word | input | 16 | Divisor word, bit 15 most significant |
| band_hi | input | 1 | 1 selects high-band stream with prescale by 2 |
| step_fine | input | 1 | In low band: 1 uses the whole word, 0 uses bits 15..4 |
| inhibit | input | 1 | Stops division |
| fb_pulse | output | 1 | One-cycle divided output pulse |
| hi_band_act | output | 1 | 1 while the high-band stream is the active source |
| in_pulldown | output | 1 | Input pull-down indicator |
| cp_hiz | output | 1 | Charge-pump high-impedance indicator |

## Verification
The terminal event and a change of divisor word or mode bits can land in the same cycle, and the new values must govern only the following period. The bench provokes this by re-randomising the word and both mode bits on every cycle while ticks arrive densely, so a terminal event often meets a fresh setting. Inhibit bursts are also dropped at random on top of terminal events. A behavioural model re-derives the pulse, active band and indicators on every clock from the requirements, and the bench compares them against the ports.

// File: rtl/fbdiv_pkg.sv
// Package: shared widths and mode-decode type for the feedback divider.
// Assumes a 16-bit divisor word with a 4-bit coarse shift by default.
package fbdiv_pkg;
    localparam int unsigned DIV_W        = 16;
    localparam int unsigned COARSE_SHIFT = 4;
    localparam int unsigned FLOOR_WIDE   = 272;
    localparam int unsigned FLOOR_COARSE = 4;

    typedef enum logic [1:0] {
        MODE_COARSE = 2'b00,
        MODE_FINE   = 2'b01,
        MODE_HIGH   = 2'b10
    } div_mode_e;

    // Decode the two mode bits into a mode value.
    function automatic div_mode_e decode_mode(input logic hi, input logic fine);
        if (hi)        return MODE_HIGH;
        else if (fine) return MODE_FINE;
        else           return MODE_COARSE;
    endfunction
endpackage

// File: rtl/fbdiv_setting.sv
// Module: fbdiv_setting
// Turns the divisor word and mode into the counter reload value (N-1).
// It picks the LSB position for the mode and applies the floor clamp.
// Assumes FLOOR values are at least 2 and fit in W bits.
module fbdiv_setting
    import fbdiv_pkg::*;
#(
    parameter int unsigned W       = DIV_W,
    parameter int unsigned SHIFT   = COARSE_SHIFT,
    parameter int unsigned FLOOR_W = FLOOR_WIDE,
    parameter int unsigned FLOOR_C = FLOOR_COARSE
) (
    input  logic [W-1:0] word,
    input  logic         hi,
    input  logic         fine,
    output logic [W-1:0] reload
);
    localparam int unsigned CW = W - SHIFT;
    localparam logic [W-1:0] FLOOR_W_V = W'(FLOOR_W);
    localparam logic [W-1:0] FLOOR_C_V = W'(FLOOR_C);

    div_mode_e   mode;
    logic [W-1:0] raw;
    logic [W-1:0] floor_v;
    logic [W-1:0] n_eff;

    // Select the setting field and floor for the current mode, clamp, subtract one.
    always_comb begin
        mode = decode_mode(hi, fine);
        if (mode == MODE_COARSE) begin
            raw     = {{SHIFT{1'b0}}, word[W-1 -: CW]};
            floor_v = FLOOR_C_V;
        end else begin
            raw     = word;
            floor_v = FLOOR_W_V;
        end
        n_eff  = (raw < floor_v) ? floor_v : raw;
        reload = n_eff - W'(1);
    end
endmodule

// File: rtl/fbdiv_prescale.sv
// Module: fbdiv_prescale
// Fixed divide-by-2 on the high-band tick stream, used only while high band is active.
// Its phase is cleared whenever high band is inactive or division is inhibited.
module fbdiv_prescale (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic act_hi,
    input  logic hf_tick,
    output logic half_tick
);
    logic phase;

    // Toggle the phase on each high-band tick; hold it at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !act_hi) phase <= 1'b0;
        else if (hf_tick)             phase <= ~phase;
    end

    assign half_tick = act_hi && hf_tick && phase && !clr;

    a_r2_tick_source: assert property (@(posedge clk) disable iff (!rst_n)
        half_tick |-> (hf_tick && act_hi));
    a_r2_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
        half_tick |=> !half_tick);
endmodule

// File: rtl/fbdiv_counter.sv
// Module: fbdiv_counter
// Down counter: a counted event at zero is terminal and reloads; other events decrement.
// Clearing forces zero, so the next counted event is terminal.
module fbdiv_counter #(
    parameter int unsigned W     = 16,
    parameter int unsigned FLOOR = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ev,
    input  logic [W-1:0] reload,
    output logic         term
);
    logic [W-1:0] cnt;
    logic         at_zero;

    assign at_zero = (cnt == '0);
    assign term    = ev && at_zero && !clr;

    // Reload at terminal count, decrement on other counted events.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (ev)       cnt <= at_zero ? reload : cnt - W'(1);
    end

    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ev && !at_zero) |=> (cnt == $past(cnt) - W'(1)));
    a_r5_reload_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ev && at_zero) |=> (cnt >= W'(FLOOR)));
    a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ev) |=> $stable(cnt));
endmodule

// File: rtl/fbdiv_top.sv
// Module: fbdiv_top
// Programmable feedback divider with band/step mode selection, prescale-by-2 in high band,
// a registered one-cycle output pulse and an inhibit that freezes division.
// Assumes hf_tick/lf_tick are synchronous one-cycle enables in the clk domain.
module fbdiv_top
    import fbdiv_pkg::*;
#(
    parameter int unsigned W       = DIV_W,
    parameter int unsigned SHIFT   = COARSE_SHIFT,
    parameter int unsigned FLOOR_W = FLOOR_WIDE,
    parameter int unsigned FLOOR_C = FLOOR_COARSE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hf_tick,
    input  logic         lf_tick,
    input  logic [W-1:0] div_word,
    input  logic         band_hi,
    input  logic         step_fine,
    input  logic         inhibit,
    output logic         fb_pulse,
    output logic         hi_band_act,
    output logic         in_pulldown,
    output logic         cp_hiz
);
    localparam int unsigned MIN_FLOOR = (FLOOR_C < FLOOR_W) ? FLOOR_C : FLOOR_W;

    logic [W-1:0] reload;
    logic         half_tick;
    logic         ev;
    logic         term;

    fbdiv_setting #(
        .W(W), .SHIFT(SHIFT), .FLOOR_W(FLOOR_W), .FLOOR_C(FLOOR_C)
    ) u_setting (
        .word   (div_word),
        .hi     (band_hi),
        .fine   (step_fine),
        .reload (reload)
    );

    fbdiv_prescale u_prescale (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (inhibit),
        .act_hi    (hi_band_act),
        .hf_tick   (hf_tick),
        .half_tick (half_tick)
    );

    // Counted event comes from the active band's stream.
    assign ev = !inhibit && (hi_band_act ? half_tick : lf_tick);

    fbdiv_counter #(
        .W(W), .FLOOR(MIN_FLOOR - 1)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (inhibit),
        .ev     (ev),
        .reload (reload),
        .term   (term)
    );

    // Latch the band at each terminal event, or track it while inhibited.
    always_ff @(posedge clk) begin
        if (!rst_n)                hi_band_act <= 1'b0;
        else if (inhibit || term)  hi_band_act <= band_hi;
    end

    // Register the terminal event into the output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || inhibit) fb_pulse <= 1'b0;
        else                   fb_pulse <= term;
    end

    assign in_pulldown = inhibit;
    assign cp_hiz      = inhibit;

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse);
    a_r8_inhibit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> !fb_pulse);
    a_r7_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inhibit && !term) |=> $stable(hi_band_act));
    a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fb_pulse) |-> $past(ev));
endmodule

// File: tb/fbdiv_top_bench.sv
// Bench: behavioural model counting events per period, compared with the ports every cycle.
module fbdiv_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hf_tick = 1'b0, lf_tick = 1'b0;
    logic [15:0] div_word = 16'd300;
    logic        band_hi = 1'b0, step_fine = 1'b1, inhibit = 1'b0;
    logic        fb_pulse, hi_band_act, in_pulldown, cp_hiz;

    int checks = 0, fails = 0, cycles = 0;
    string cur_req = "R1";
    bit chk_on = 0;

    always #4 clk = ~clk;

    fbdiv_top u_fbdiv_top (
        .clk(clk), .rst_n(rst_n), .hf_tick(hf_tick), .lf_tick(lf_tick),
        .div_word(div_word), .band_hi(band_hi), .step_fine(step_fine),
        .inhibit(inhibit), .fb_pulse(fb_pulse), .hi_band_act(hi_band_act),
        .in_pulldown(in_pulldown), .cp_hiz(cp_hiz)
    );

    // Period length in counted events, from R2..R5.
    function automatic int period_of(input logic [15:0] w, input logic hi, input logic fine);
        int n;
        if (!hi && !fine) begin
            n = int'(w) / 16;
            if (n < 4) n = 4;
        end else begin
            n = int'(w);
            if (n < 272) n = 272;
        end
        return n;
    endfunction

    // Model state
    bit m_pulse = 0, m_hi = 0, m_armed = 1, m_half = 0;
    int m_seen = 0, m_period = 1;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_pulse = 0; m_hi = 0; m_armed = 1; m_half = 0; m_seen = 0;
        end else if (inhibit) begin
            m_pulse = 0; m_hi = band_hi; m_armed = 1; m_half = 0; m_seen = 0;
        end else begin
            bit counted;
            counted = 0;
            m_pulse = 0;
            if (m_hi) begin
                if (hf_tick) begin
                    counted = m_half;
                    m_half = !m_half;
                end
            end else begin
                counted = lf_tick;
            end
            if (counted) begin
                if (m_armed || (m_seen + 1 == m_period)) begin
                    m_pulse = 1;
                    m_period = period_of(div_word, band_hi, step_fine);
                    m_hi = band_hi;
                    m_seen = 0;
                    m_armed = 0;
                    m_half = 0;
                end else begin
                    m_seen++;
                end
            end
        end
    end

    task automatic check1(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Compare every cycle, 2 ns after the edge.
    always @(posedge clk) begin
        #2;
        if (chk_on) begin
            check1("fb_pulse", fb_pulse, m_pulse);
            check1("hi_band_act", hi_band_act, m_hi);
            check1("in_pulldown R9", in_pulldown, inhibit);
            check1("cp_hiz R9", cp_hiz, inhibit);
        end
    end

    task automatic run(input int n, input int p_lf, input int p_hf);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lf_tick = (($urandom % 100) < p_lf);
            hf_tick = (($urandom % 100) < p_hf);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        while (cycles < 180000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        @(posedge clk); #2; chk_on = 1;
        run(4, 100, 100);
        @(negedge clk); rst_n = 1'b1;
        // R3 / R10-style first pulse after reset (R8): fine low band, hf noise
        cur_req = "R3";
        div_word = 16'd300; band_hi = 0; step_fine = 1;
        run(2000, 80, 50);
        // R2: high band, lf noise, setting at the floor
        cur_req = "R2";
        band_hi = 1; div_word = 16'd272;
        run(2500, 60, 90);
        // R4: coarse mode, low nibble wiggles
        cur_req = "R4";
        band_hi = 0; step_fine = 0; div_word = 16'h0057;
        for (int k = 0; k < 40; k++) begin
            div_word[3:0] = 4'($urandom);
            run(25, 90, 90);
        end
        // R5: floors in both families
        cur_req = "R5";
        div_word = 16'h002F; run(300, 100, 0);
        step_fine = 1; div_word = 16'd10; run(1200, 100, 0);
        band_hi = 1; div_word = 16'd3; run(1800, 0, 100);
        // R7: settings and mode re-randomised every cycle
        cur_req = "R7";
        for (int k = 0; k < 6000; k++) begin
            @(negedge clk);
            band_hi   = (($urandom % 4) == 0);
            step_fine = (($urandom % 4) == 0);
            div_word  = step_fine || band_hi ? 16'(272 + $urandom % 6) : 16'($urandom % 160);
            lf_tick   = (($urandom % 100) < 85);
            hf_tick   = (($urandom % 100) < 85);
        end
        // R6: densest coarse ticking gives minimum spacing
        cur_req = "R6";
        band_hi = 0; step_fine = 0; div_word = 16'h0040;
        run(400, 100, 100);
        // R8 / R9: inhibit bursts on top of activity
        cur_req = "R8";
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            inhibit = 1'b1;
            band_hi = $urandom % 2;
            step_fine = 1'b0;
            div_word = 16'(16 * (4 + $urandom % 6));
            run(1 + $urandom % 5, 100, 100);
            @(negedge clk); inhibit = 1'b0;
            run(30 + $urandom % 40, 90, 90);
        end
        cur_req = "R9";
        @(negedge clk); inhibit = 1'b1; run(10, 100, 100);
        @(negedge clk); inhibit = 1'b0; run(10, 100, 100);
        // R1 again: reset mid-run
        cur_req = "R1";
        @(negedge clk); rst_n = 1'b0; run(3, 100, 100);
        @(negedge clk); rst_n = 1'b1; run(50, 100, 100);
        @(negedge clk);
        finish_run();
    end
endmodule